// File: doc/BRIEF.md
# PRBS Pattern Checker with Error Counters

The block is a stream sink that compares each incoming data beat against a reference pattern picked by software. The pattern can be one of four pseudo-random binary sequences or one of two constant patterns. The PRBS reference synchronises itself to the stream: it predicts each beat from the beat received before it, so no seed register is needed and no alignment search is done.

A lock detector watches the comparison results and reports whether the stream is following the pattern. While it reports lock, two 64-bit counters accumulate the number of bits received and the number of bit errors. Software never reads these counters directly. A snapshot command copies both counters at once into readable registers, and a separate clear command zeroes the counters and the snapshot registers.

The sink keeps `in_ready` high at all times, so it never applies back-pressure. A beat is taken on every clock edge where `in_valid` is high. Beats that arrive while checking is disabled are discarded. `DATA_W` must be a multiple of 8 and at least 31. Beat bit 0 is the earliest bit in time.

Top module: `patchk_top`

## Requirements
- R1: After reset the checker is disabled and unlocked, `in_ready` is 1, and registers at offsets 0, 2, 3, 4, 5, 6 and 7 read 0. The pattern register (offset 1) reads 0x1, which selects PRBS7.
- R2: `in_ready` is always 1. A beat is used only when `in_valid` is 1 and the enable bit (offset 0, bit 0) is 1. Beats that arrive while disabled leave the lock state and the counts unchanged.
- R3: The pattern register (offset 1) is one-hot. Bits 0 to 3 select PRBS with the recurrence s[n] = s[n-N] xor s[n-M], where (N,M) is (7,6), (15,14), (23,18) or (31,28) in that bit order. Bit 4 selects an alternating pattern: every beat equals 0xAAAAAAAA for a 32-bit width. Bit 5 selects a low-frequency pattern: every byte equals 0x0F.
- R4: The first used beat after the checker is enabled only seeds the reference. Each later used beat is compared with the continuation of the previous used beat. Its error count is the popcount of (data xor expected).
- R5: Lock is set by the 16th consecutive error-free compared beat. It is cleared by the 4th consecutive compared beat that has errors. Disabling the checker clears lock. Lock is shown on the `locked` pin and on offset 0, bit 1.
- R6: Writes to offset 0, bit 1 have no effect. Writes to the pattern register are ignored while the checker is enabled.
- R7: A compared beat adds DATA_W to the bit count and its error popcount to the error count. This happens only if lock was already set before that beat.
- R8: Writing 1 to offset 2, bit 0 copies both counts in the same cycle. The bit count goes to offsets 3 (low) and 4 (high), and the error count to offsets 5 (low) and 6 (high). The copied values exclude any beat used in that same cycle. The copy also works while the checker is disabled.
- R9: Writing 1 to offset 2, bit 1 zeroes both counts and all snapshot registers. If the same write also requests a snapshot, the clear takes precedence. Offset 2 reads 0. Disabling and then re-enabling the checker does not clear the counts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Beat present on `in_data` |
| in_data | input | DATA_W | Received beat, bit 0 earliest |
| in_ready | output | 1 | Always 1; the sink never stalls |
| reg_addr | input | 3 | Register offset |
| reg_wen | input | 1 | Write strobe for one cycle |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr`, combinational |
| locked | output | 1 | Lock status |

## Verification
Three events can fall in the same clock cycle: a snapshot request, a counted beat, and a clear request. The bench drives a snapshot write in the same cycle as a locked, accepted beat. It expects the snapshot to hold the count from before that beat, and a second snapshot to include the beat. It also issues a combined clear-and-snapshot write after counts have built up, and expects every snapshot half to read zero.

// File: rtl/patchk_pkg.sv
package patchk_pkg;
  localparam int SEL_W = 6;
  localparam int REG_W = 32;
  localparam int ADDR_W = 3;

  typedef enum logic [ADDR_W-1:0] {
    A_STATUS  = 3'd0,
    A_PATTERN = 3'd1,
    A_CTRL    = 3'd2,
    A_BITS_LO = 3'd3,
    A_BITS_HI = 3'd4,
    A_ERRS_LO = 3'd5,
    A_ERRS_HI = 3'd6
  } reg_addr_e;

  typedef struct packed {
    logic       valid;
    logic [4:0] len;
    logic [4:0] tap;
  } taps_t;

  // Map the one-hot selector onto recurrence lengths s[n]=s[n-len]^s[n-tap].
  function automatic taps_t prbs_taps(input logic [SEL_W-1:0] sel);
    taps_t t;
    t = '0;
    if (sel[0])      t = '{1'b1, 5'd7,  5'd6};
    else if (sel[1]) t = '{1'b1, 5'd15, 5'd14};
    else if (sel[2]) t = '{1'b1, 5'd23, 5'd18};
    else if (sel[3]) t = '{1'b1, 5'd31, 5'd28};
    return t;
  endfunction
endpackage

// File: rtl/patchk_ref.sv
module patchk_ref
  import patchk_pkg::*;
#(
  parameter  int DATA_W = 32,
  localparam int ERR_W  = $clog2(DATA_W + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              beat,
  input  logic [DATA_W-1:0] data,
  input  logic [SEL_W-1:0]  sel,
  output logic              cmp_valid,
  output logic [ERR_W-1:0]  err_bits
);
  logic [DATA_W-1:0] hist;
  logic [DATA_W-1:0] expv;
  logic [DATA_W-1:0] diff;
  logic              primed;

  // The previous used beat is the whole reference state.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hist   <= '0;
      primed <= 1'b0;
    end else if (!en) begin
      primed <= 1'b0;
    end else if (beat) begin
      primed <= 1'b1;
      hist   <= data;
    end
  end

  always_comb begin
    taps_t t;
    int    n;
    int    m;
    logic  a;
    logic  b;
    t    = prbs_taps(sel);
    n    = int'(t.len);
    m    = int'(t.tap);
    expv = '0;
    a    = 1'b0;
    b    = 1'b0;
    if (sel[4]) begin
      for (int i = 0; i < DATA_W; i++) expv[i] = (i % 2) == 1;
    end else if (sel[5]) begin
      for (int i = 0; i < DATA_W; i++) expv[i] = (i % 8) < 4;
    end else if (t.valid) begin
      for (int k = 0; k < DATA_W; k++) begin
        if (k < n) a = hist[DATA_W - n + k];
        else       a = expv[k - n];
        if (k < m) b = hist[DATA_W - m + k];
        else       b = expv[k - m];
        expv[k] = a ^ b;
      end
    end
  end

  assign diff = data ^ expv;

  always_comb begin
    err_bits = '0;
    for (int i = 0; i < DATA_W; i++) err_bits = err_bits + ERR_W'(diff[i]);
  end

  assign cmp_valid = beat & primed;
endmodule

// File: rtl/patchk_lock.sv
module patchk_lock #(
  parameter  int GOOD_RUN = 16,
  parameter  int BAD_RUN  = 4,
  localparam int GW = $clog2(GOOD_RUN + 1),
  localparam int BW = $clog2(BAD_RUN + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic cmp_valid,
  input  logic cmp_err,
  output logic locked
);
  logic [GW-1:0] good;
  logic [BW-1:0] bad;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      locked <= 1'b0;
      good   <= '0;
      bad    <= '0;
    end else if (!en) begin
      locked <= 1'b0;
      good   <= '0;
      bad    <= '0;
    end else if (cmp_valid) begin
      if (!locked) begin
        if (cmp_err) begin
          good <= '0;
        end else if (good == GW'(GOOD_RUN - 1)) begin
          locked <= 1'b1;
          good   <= '0;
        end else begin
          good <= good + 1'b1;
        end
      end else begin
        if (!cmp_err) begin
          bad <= '0;
        end else if (bad == BW'(BAD_RUN - 1)) begin
          locked <= 1'b0;
          bad    <= '0;
        end else begin
          bad <= bad + 1'b1;
        end
      end
    end
  end

  // R5
  lock_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(locked) |-> $past(en && cmp_valid && !cmp_err));
  // R5
  lock_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(locked) |-> $past(!en || (cmp_valid && cmp_err)));
  // R5
  dis_unlock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> !locked);
endmodule

// File: rtl/patchk_cnt.sv
module patchk_cnt #(
  parameter int DATA_W = 32,
  parameter int CNT_W  = 64,
  parameter int ERR_W  = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             count_en,
  input  logic [ERR_W-1:0] err_bits,
  input  logic             snap,
  input  logic             clr,
  output logic [CNT_W-1:0] snap_bits,
  output logic [CNT_W-1:0] snap_errs
);
  logic [CNT_W-1:0] bits;
  logic [CNT_W-1:0] errs;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bits      <= '0;
      errs      <= '0;
      snap_bits <= '0;
      snap_errs <= '0;
    end else if (clr) begin
      bits      <= '0;
      errs      <= '0;
      snap_bits <= '0;
      snap_errs <= '0;
    end else begin
      if (count_en) begin
        bits <= bits + CNT_W'(DATA_W);
        errs <= errs + CNT_W'(err_bits);
      end
      if (snap) begin
        snap_bits <= bits;
        snap_errs <= errs;
      end
    end
  end

  // R7
  bits_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(clr) |-> (bits == $past(bits) || bits == $past(bits) + CNT_W'(DATA_W)));
  // R7
  errs_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(clr) |-> (errs - $past(errs) <= CNT_W'(DATA_W)));
  // R9
  clear_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(clr) |-> (snap_bits == '0 && snap_errs == '0 && bits == '0 && errs == '0));
  // R8
  snap_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(snap) && !$past(clr)) |-> ($stable(snap_bits) && $stable(snap_errs)));
endmodule

// File: rtl/patchk_regs.sv
module patchk_regs
  import patchk_pkg::*;
#(
  parameter int CNT_W = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_wen,
  input  logic [REG_W-1:0]  reg_wdata,
  output logic [REG_W-1:0]  reg_rdata,
  input  logic              locked,
  input  logic [CNT_W-1:0]  snap_bits,
  input  logic [CNT_W-1:0]  snap_errs,
  output logic              en,
  output logic [SEL_W-1:0]  sel,
  output logic              snap,
  output logic              clr
);
  logic wr_status;
  logic wr_pattern;
  logic wr_ctrl;

  assign wr_status  = reg_wen && (reg_addr == A_STATUS);
  assign wr_pattern = reg_wen && (reg_addr == A_PATTERN);
  assign wr_ctrl    = reg_wen && (reg_addr == A_CTRL);
  assign snap       = wr_ctrl && reg_wdata[0];
  assign clr        = wr_ctrl && reg_wdata[1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en  <= 1'b0;
      sel <= SEL_W'(1);
    end else begin
      if (wr_status) en <= reg_wdata[0];
      if (wr_pattern && !en) sel <= reg_wdata[SEL_W-1:0];
    end
  end

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      A_STATUS:  reg_rdata = {{(REG_W-2){1'b0}}, locked, en};
      A_PATTERN: reg_rdata = {{(REG_W-SEL_W){1'b0}}, sel};
      A_BITS_LO: reg_rdata = snap_bits[REG_W-1:0];
      A_BITS_HI: reg_rdata = snap_bits[CNT_W-1:REG_W];
      A_ERRS_LO: reg_rdata = snap_errs[REG_W-1:0];
      A_ERRS_HI: reg_rdata = snap_errs[CNT_W-1:REG_W];
      default:   reg_rdata = '0;
    endcase
  end

  // R6
  sel_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(en) |-> $stable(sel));
endmodule

// File: rtl/patchk_top.sv
module patchk_top
  import patchk_pkg::*;
#(
  parameter int DATA_W   = 32,
  parameter int GOOD_RUN = 16,
  parameter int BAD_RUN  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] in_data,
  output logic              in_ready,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_wen,
  input  logic [REG_W-1:0]  reg_wdata,
  output logic [REG_W-1:0]  reg_rdata,
  output logic              locked
);
  localparam int CNT_W = 2 * REG_W;
  localparam int ERR_W = $clog2(DATA_W + 1);

  logic             en;
  logic [SEL_W-1:0] sel;
  logic             snap;
  logic             clr;
  logic             beat;
  logic             cmp_valid;
  logic [ERR_W-1:0] err_bits;
  logic [CNT_W-1:0] snap_bits;
  logic [CNT_W-1:0] snap_errs;

  assign in_ready = 1'b1;
  assign beat     = in_valid & en;

  patchk_regs #(.CNT_W(CNT_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wen(reg_wen),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .locked(locked),
    .snap_bits(snap_bits), .snap_errs(snap_errs), .en(en), .sel(sel),
    .snap(snap), .clr(clr)
  );

  patchk_ref #(.DATA_W(DATA_W)) u_ref (
    .clk(clk), .rst_n(rst_n), .en(en), .beat(beat), .data(in_data),
    .sel(sel), .cmp_valid(cmp_valid), .err_bits(err_bits)
  );

  patchk_lock #(.GOOD_RUN(GOOD_RUN), .BAD_RUN(BAD_RUN)) u_lock (
    .clk(clk), .rst_n(rst_n), .en(en), .cmp_valid(cmp_valid),
    .cmp_err(err_bits != '0), .locked(locked)
  );

  patchk_cnt #(.DATA_W(DATA_W), .CNT_W(CNT_W), .ERR_W(ERR_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .count_en(cmp_valid & locked),
    .err_bits(err_bits), .snap(snap), .clr(clr),
    .snap_bits(snap_bits), .snap_errs(snap_errs)
  );

  // R2
  unused_beat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en |-> !cmp_valid);
endmodule

// File: tb/sim_patchk_top.sv
`timescale 1ns/1ps
module sim_patchk_top;
  localparam int W = 32;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          in_valid = 1'b0;
  logic [W-1:0]  in_data = '0;
  logic          in_ready;
  logic [2:0]    reg_addr = '0;
  logic          reg_wen = 1'b0;
  logic [31:0]   reg_wdata = '0;
  logic [31:0]   reg_rdata;
  logic          locked;

  always #2 clk = ~clk;

  patchk_top #(.DATA_W(W)) u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
    .in_ready(in_ready), .reg_addr(reg_addr), .reg_wen(reg_wen),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .locked(locked)
  );

  int n_chk = 0;
  int n_fail = 0;
  bit lock_q[$];

  bit          m_en = 0, m_primed = 0, m_lock = 0;
  int          m_good = 0, m_bad = 0;
  logic [W-1:0] m_hist = '0;
  logic [5:0]  m_sel = 6'd1;
  logic [63:0] m_bits = '0, m_errs = '0, m_sb = '0, m_se = '0;

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  // Pattern continuation from the requirement text (R3).
  function automatic logic [W-1:0] pat_next(input logic [W-1:0] prev, input logic [5:0] sel);
    logic [2*W-1:0] s;
    int n, m;
    if (sel[4]) return {(W/2){2'b10}};
    if (sel[5]) return {(W/8){8'h0F}};
    if (sel[0]) begin n = 7; m = 6; end
    else if (sel[1]) begin n = 15; m = 14; end
    else if (sel[2]) begin n = 23; m = 18; end
    else if (sel[3]) begin n = 31; m = 28; end
    else return '0;
    s = '0;
    s[W-1:0] = prev;
    for (int k = W; k < 2*W; k++) s[k] = s[k-n] ^ s[k-m];
    return s[2*W-1:W];
  endfunction

  task automatic model_beat(input logic [W-1:0] d);
    int e;
    if (m_en) begin
      if (!m_primed) m_primed = 1;
      else begin
        e = $countones(d ^ pat_next(m_hist, m_sel));
        if (m_lock) begin m_bits += 64'(W); m_errs += 64'(e); end
        if (!m_lock) begin
          if (e == 0) begin
            m_good++;
            if (m_good == 16) begin m_lock = 1; m_good = 0; end
          end else m_good = 0;
        end else begin
          if (e != 0) begin
            m_bad++;
            if (m_bad == 4) begin m_lock = 0; m_bad = 0; end
          end else m_bad = 0;
        end
      end
      m_hist = d;
    end
    lock_q.push_back(m_lock);
  endtask

  task automatic model_wr(input logic [2:0] a, input logic [31:0] wd);
    if (a == 3'd0) begin
      m_en = wd[0];
      if (!wd[0]) begin m_primed = 0; m_lock = 0; m_good = 0; m_bad = 0; end
    end else if (a == 3'd1) begin
      if (!m_en) m_sel = wd[5:0];
    end else if (a == 3'd2) begin
      if (wd[1]) begin m_bits = '0; m_errs = '0; m_sb = '0; m_se = '0; end
      else if (wd[0]) begin m_sb = m_bits; m_se = m_errs; end
    end
  endtask

  // Driver: one cycle of stimulus, expected lock pushed to the scoreboard.
  task automatic drive(input bit v, input logic [W-1:0] d, input bit w,
                       input logic [2:0] a, input logic [31:0] wd);
    @(negedge clk);
    in_valid = v; in_data = d; reg_wen = w; reg_addr = a; reg_wdata = wd;
    if (w) model_wr(a, wd);
    if (v) model_beat(d);
  endtask

  task automatic idle();
    drive(0, '0, 0, 3'd0, '0);
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] wd);
    drive(0, '0, 1, a, wd);
    idle();
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] v);
    @(negedge clk);
    in_valid = 0; reg_wen = 0; reg_addr = a;
    #1 v = reg_rdata;
  endtask

  task automatic rd64(input logic [2:0] lo, output logic [63:0] v);
    logic [31:0] l, h;
    rd(lo, l);
    rd(lo + 3'd1, h);
    v = {h, l};
  endtask

  task automatic check_snaps(input string req);
    logic [63:0] b, e;
    rd64(3'd3, b);
    rd64(3'd5, e);
    check({req, " bits"}, b, m_sb);
    check({req, " errs"}, e, m_se);
  endtask

  task automatic send(input int cnt, inout logic [W-1:0] cur);
    for (int i = 0; i < cnt; i++) begin
      drive(1, cur, 0, 3'd0, '0);
      cur = pat_next(cur, m_sel);
    end
    idle();
  endtask

  // Monitor: after each accepted beat, compare the lock pin (R5).
  initial begin
    forever begin
      @(posedge clk);
      if (rst_n && in_valid) begin
        @(negedge clk);
        if (lock_q.size() == 0) check("R5 scoreboard underflow", 1, 0);
        else check("R5 lock after beat", 64'(locked), 64'(lock_q.pop_front()));
      end
    end
  end

  bit done = 0;
  initial begin
    #(200000 * 4);
    if (!done) begin
      check("watchdog", 1, 0);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    logic [63:0] b, e;
    logic [W-1:0] cur;
    logic [5:0] sels [5];
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset state
    for (int a = 0; a < 8; a++) begin
      rd(3'(a), v);
      check("R1 reset register", v, (a == 1) ? 64'd1 : 64'd0);
    end
    check("R1 locked", locked, 0);
    check("R1 R2 ready", in_ready, 1);

    // PRBS7 acquisition
    wr(3'd1, 32'h1);
    wr(3'd0, 32'h1);
    cur = 32'hDEADBEEF;
    send(30, cur);
    wr(3'd2, 32'h1);
    check_snaps("R7 R8 first lock");
    rd64(3'd3, b);
    check("R7 bits after 30 beats", b, 64'(13 * W));
    rd(3'd0, v);
    check("R5 status lock bit", v, 3);

    // R6 lock bit not writable, pattern frozen while enabled
    wr(3'd0, 32'h1);
    rd(3'd0, v);
    check("R6 lock bit write ignored", v, 3);
    wr(3'd1, 32'h2);
    rd(3'd1, v);
    check("R6 pattern frozen", v, 1);

    // R4 R7 single injected error
    drive(1, cur ^ 32'h20, 0, 3'd0, '0);
    cur = pat_next(cur, m_sel);
    send(10, cur);
    wr(3'd2, 32'h1);
    check_snaps("R4 R7 injected error");
    rd64(3'd5, e);
    check("R4 one bit error", e, 1);

    // R8 snapshot in same cycle as a counted beat
    drive(1, cur, 1, 3'd2, 32'h1);
    cur = pat_next(cur, m_sel);
    idle();
    rd64(3'd3, b);
    check("R8 same-cycle snapshot excludes beat", b, 64'((13 + 11) * W));
    check_snaps("R8 same-cycle snapshot");
    wr(3'd2, 32'h1);
    check_snaps("R8 later snapshot includes beat");

    // R5 lock drop on four bad beats, with error propagation
    for (int i = 0; i < 4; i++) begin
      drive(1, ~cur, 0, 3'd0, '0);
      cur = pat_next(cur, m_sel);
    end
    idle();
    rd(3'd0, v);
    check("R5 lock dropped", v, 1);
    wr(3'd0, 32'h3);
    rd(3'd0, v);
    check("R6 lock bit set attempt", v, 1);

    // R8 snapshot while disabled, R2 beats ignored while disabled
    wr(3'd0, 32'h0);
    check("R5 disabled unlocked", locked, 0);
    send(5, cur);
    wr(3'd2, 32'h1);
    check_snaps("R2 R8 snapshot while disabled");
    // R9 re-enable keeps counts
    wr(3'd0, 32'h1);
    wr(3'd2, 32'h1);
    check_snaps("R9 re-enable keeps counts");
    wr(3'd0, 32'h0);
    rd64(3'd3, b);
    check("R9 counts nonzero before clear", 64'(b != 0), 1);
    // R9 clear and clear precedence
    wr(3'd2, 32'h3);
    check_snaps("R9 clear with snapshot");
    rd64(3'd3, b);
    check("R9 cleared bits", b, 0);
    wr(3'd2, 32'h1);
    check_snaps("R9 internal counts cleared");
    rd(3'd2, v);
    check("R9 control reads zero", v, 0);

    // R3 every pattern
    sels[0] = 6'h02; sels[1] = 6'h04; sels[2] = 6'h08; sels[3] = 6'h10; sels[4] = 6'h20;
    for (int p = 0; p < 5; p++) begin
      wr(3'd2, 32'h2);
      wr(3'd1, 32'(sels[p]));
      wr(3'd0, 32'h1);
      cur = p < 3 ? 32'hDEADBEEF : pat_next('0, sels[p]);
      send(30, cur);
      wr(3'd2, 32'h1);
      rd64(3'd3, b);
      rd64(3'd5, e);
      check($sformatf("R3 pattern 0x%0h bits", sels[p]), b, 64'(13 * W));
      check($sformatf("R3 pattern 0x%0h errs", sels[p]), e, 0);
      wr(3'd0, 32'h0);
    end
    // R3 low-frequency with a bad byte
    wr(3'd0, 32'h1);
    cur = {(W/8){8'h0F}};
    send(20, cur);
    drive(1, 32'h0F0F_F00F, 0, 3'd0, '0);
    idle();
    wr(3'd2, 32'h1);
    check_snaps("R3 low-frequency errors");
    rd64(3'd5, e);
    check("R3 low-frequency error count", e, 8);

    repeat (3) @(negedge clk);
    check("R5 scoreboard drained", lock_q.size(), 0);
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule